// File: doc/BRIEF.md
# Directed-Rounding Result Corrector

This block sits behind a floating-point datapath that can only round to nearest or toward zero. It receives the 64-bit destination value that datapath produced, along with the lane inexact indications, the rounding mode in force, the kind of operation and the source operand sign bits. When the mode asks for rounding toward plus or minus infinity, it nudges the result by one unit in the last place wherever the datapath rounded the wrong way. The 64-bit value is read as one of three layouts: a single 32-bit value in the low word, one 64-bit double, or two independent 32-bit lanes.

Float results move by one in magnitude. Integer conversion results move by one in value. For a double float the step runs across the whole 64-bit word, so a carry out of the low half reaches the high half. Compare operations have no value to correct. They come back flagged as an error and are not written back.

The block takes one request per cycle with no stall. Each answer is registered and appears one cycle after its request.

Top module: `dr_round_fix`

## Requirements
- R1: `out_valid` rises in the cycle after a cycle with `in_valid` high and is low otherwise. `out_result`, `out_write` and `out_error` change only together with it. While reset is held low, `out_valid`, `out_write` and `out_error` are 0.
- R2: Rounding modes 0 (nearest even) and 1 (toward zero) return `in_result` unchanged.
- R3: A lane with its inexact bit low is not changed. `in_inexact_hi` has effect only when `in_fmt` is 2 (paired singles). With format 0 (single) or 1 (double), only `in_inexact_lo` counts.
- R4: Kind 3 (conversion that always truncates) is never changed, whatever the mode.
- R5: In mode 2 (toward plus infinity), an inexact lane whose sign is positive is incremented by one.
- R6: In mode 3 (toward minus infinity), an inexact lane whose sign is negative is incremented by one when kind is 0 (float result) and decremented by one when kind is 1 or 2 (integer result). A positive lane in mode 3 and a negative lane in mode 2 are left unchanged.
- R7: With format 1 and kind 0 (double float), the sign is bit 63 and the increment covers all 64 bits, so a carry crosses from bit 31 into bit 32.
- R8: For kind 2 (signed integer), the lane sign is bit 31 of the lane word. When that word is zero, the sign comes from the lane's source sign input instead (`in_src_sign_lo` or `in_src_sign_hi`).
- R9: For kind 1 (unsigned integer), the sign is always taken as positive. Integer kinds in formats 0 and 1 correct only bits 31:0 and return bits 63:32 unchanged.
- R10: In format 2, the low lane (bits 31:0) and the high lane (bits 63:32) are corrected separately, each with its own inexact bit and sign. Each increment or decrement wraps within its 32-bit lane. In format 0, bits 63:32 pass unchanged.
- R11: Kinds 4 to 7 (compare) produce `out_error`=1 and `out_write`=0, with `out_result` equal to `in_result`. Every other kind gives `out_write`=1 and `out_error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_result | input | 64 | Result word from the nearest/zero datapath |
| in_fmt | input | 2 | Layout: 0 single, 1 double, 2 paired singles |
| in_kind | input | 3 | 0 float, 1 unsigned int, 2 signed int, 3 truncating conversion, 4-7 compare |
| in_rmode | input | 2 | 0 nearest, 1 zero, 2 plus infinity, 3 minus infinity |
| in_inexact_lo | input | 1 | Low lane (or the whole double) was rounded |
| in_inexact_hi | input | 1 | High lane was rounded |
| in_src_sign_lo | input | 1 | Sign of the source operand for the low lane |
| in_src_sign_hi | input | 1 | Sign of the source operand for the high lane |
| out_valid | output | 1 | Registered answer present |
| out_result | output | 64 | Corrected result |
| out_write | output | 1 | Result is to be written back |
| out_error | output | 1 | Operation rejected (compare) |

## Verification
The assertions assume that `in_fmt` never takes the value 3. They also assume that inputs are meaningful only in cycles where `in_valid` is high, and they constrain nothing while it is low. The stimulus draws formats only from 0 to 2 and keeps every input stable between the driving edges. It mixes directed words chosen at carry and wrap boundaries and at zero results with randomly drawn requests, and it inserts idle gaps so that the valid strobe is exercised in both directions.

// File: rtl/dr_pkg.sv
// Package for the directed-rounding corrector: the format, kind and
// rounding-mode codes. Assumes the codes below are fixed by the producer.
package dr_pkg;
    typedef enum logic [1:0] {
        FMT_SINGLE = 2'd0,
        FMT_DOUBLE = 2'd1,
        FMT_PAIR   = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'd0,
        RM_ZERO  = 2'd1,
        RM_UP    = 2'd2,
        RM_DOWN  = 2'd3
    } rmode_e;

    localparam logic [2:0] KIND_FLOAT = 3'd0;
    localparam logic [2:0] KIND_UINT  = 3'd1;
    localparam logic [2:0] KIND_SINT  = 3'd2;
    localparam logic [2:0] KIND_TRUNC = 3'd3;

    // Decoded controls shared by the lane and wide correctors.
    typedef struct packed {
        logic reject;     // compare kind, no write-back
        logic allow;      // directed mode and correctable kind
        logic is_float;   // float result: step in magnitude
        logic is_signed;  // signed integer result
        logic wide;       // whole-word double float step
        logic paired;     // upper lane corrected independently
    } ctrl_t;
endpackage

// File: rtl/dr_ctrl.sv
// Decodes kind, format and rounding mode into correction controls.
// Assumes kind codes 4..7 all denote compares.
module dr_ctrl
    import dr_pkg::*;
(
    input  logic [1:0] fmt_i,
    input  logic [2:0] kind_i,
    input  logic [1:0] rmode_i,
    output ctrl_t      ctrl_o
);
    // Purpose: map the request codes onto the control struct.
    always_comb begin
        logic directed;
        directed         = (rmode_i == RM_UP) || (rmode_i == RM_DOWN);
        ctrl_o.reject    = kind_i[2];
        ctrl_o.allow     = directed && !kind_i[2] && (kind_i != KIND_TRUNC);
        ctrl_o.is_float  = (kind_i == KIND_FLOAT);
        ctrl_o.is_signed = (kind_i == KIND_SINT);
        ctrl_o.wide      = (fmt_i == FMT_DOUBLE) && (kind_i == KIND_FLOAT);
        ctrl_o.paired    = (fmt_i == FMT_PAIR);
    end
endmodule

// File: rtl/dr_lane_fix.sv
// Corrects one lane word by +1 or -1 for directed rounding. Assumes the
// caller has already gated `active_i` with mode, kind and inexactness.
module dr_lane_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] word_i,
    input  logic         active_i,
    input  logic         src_sign_i,
    input  logic         is_float_i,
    input  logic         is_signed_i,
    input  logic [1:0]   rmode_i,
    output logic [W-1:0] word_o
);
    import dr_pkg::*;

    logic sign;

    // Purpose: pick the effective sign of the lane.
    always_comb begin
        if (is_float_i)
            sign = word_i[W-1];
        else if (is_signed_i)
            sign = (word_i == '0) ? src_sign_i : word_i[W-1];
        else
            sign = 1'b0;
    end

    // Purpose: apply the one-unit step that the mode and sign call for.
    always_comb begin
        word_o = word_i;
        if (active_i) begin
            if (rmode_i == RM_UP && !sign)
                word_o = word_i + W'(1);
            else if (rmode_i == RM_DOWN && sign)
                word_o = is_float_i ? word_i + W'(1) : word_i - W'(1);
        end
    end
endmodule

// File: rtl/dr_wide_fix.sv
// Full-width increment for a double float result. Assumes a double is
// only ever stepped upward in magnitude, never decremented.
module dr_wide_fix #(
    parameter int W = 64
) (
    input  logic [W-1:0] word_i,
    input  logic         active_i,
    input  logic [1:0]   rmode_i,
    output logic [W-1:0] word_o
);
    import dr_pkg::*;

    // Purpose: step the magnitude when the mode points away from zero.
    always_comb begin
        logic step;
        step = active_i &&
               ((rmode_i == RM_UP && !word_i[W-1]) ||
                (rmode_i == RM_DOWN && word_i[W-1]));
        word_o = step ? word_i + W'(1) : word_i;
    end
endmodule

// File: rtl/dr_round_fix.sv
// Top of the directed-rounding corrector. Combinational correction of the
// request, registered on the way out. Assumes in_fmt never equals 3.
module dr_round_fix #(
    parameter int LANE_W = 32,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [LANE_W*LANES-1:0]  in_result,
    input  logic [1:0]               in_fmt,
    input  logic [2:0]               in_kind,
    input  logic [1:0]               in_rmode,
    input  logic                     in_inexact_lo,
    input  logic                     in_inexact_hi,
    input  logic                     in_src_sign_lo,
    input  logic                     in_src_sign_hi,
    output logic                     out_valid,
    output logic [LANE_W*LANES-1:0]  out_result,
    output logic                     out_write,
    output logic                     out_error
);
    import dr_pkg::*;

    localparam int DATA_W = LANE_W * LANES;

    ctrl_t              ctrl;
    logic [LANES-1:0]   lane_inexact;
    logic [LANES-1:0]   lane_srcsign;
    logic [LANES-1:0]   lane_active;
    logic [DATA_W-1:0]  lane_word;
    logic [DATA_W-1:0]  wide_word;
    logic [DATA_W-1:0]  next_result;

    dr_ctrl u_ctrl (
        .fmt_i   (in_fmt),
        .kind_i  (in_kind),
        .rmode_i (in_rmode),
        .ctrl_o  (ctrl)
    );

    assign lane_inexact = {in_inexact_hi, in_inexact_lo};
    assign lane_srcsign = {in_src_sign_hi, in_src_sign_lo};

    // One corrector per lane; lane 0 always eligible, the rest only paired.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign lane_active[g] = ctrl.allow && !ctrl.wide && lane_inexact[g];
        end else begin : g_up
            assign lane_active[g] = ctrl.allow && ctrl.paired && lane_inexact[g];
        end

        dr_lane_fix #(.W(LANE_W)) u_lane (
            .word_i      (in_result[g*LANE_W +: LANE_W]),
            .active_i    (lane_active[g]),
            .src_sign_i  (lane_srcsign[g]),
            .is_float_i  (ctrl.is_float),
            .is_signed_i (ctrl.is_signed),
            .rmode_i     (in_rmode),
            .word_o      (lane_word[g*LANE_W +: LANE_W])
        );
    end

    dr_wide_fix #(.W(DATA_W)) u_wide (
        .word_i   (in_result),
        .active_i (ctrl.allow && ctrl.wide && in_inexact_lo),
        .rmode_i  (in_rmode),
        .word_o   (wide_word)
    );

    // Purpose: choose the wide or per-lane corrected word.
    always_comb begin
        next_result = ctrl.wide ? wide_word : lane_word;
    end

    // Purpose: register the answer and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_write  <= 1'b0;
            out_error  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= next_result;
                out_write  <= !ctrl.reject;
                out_error  <= ctrl.reject;
            end
        end
    end
endmodule

// File: rtl/dr_round_fix_chk.sv
// Property checker for dr_round_fix, bound to every instance.
module dr_round_fix_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_result,
    input logic [1:0]        in_fmt,
    input logic [2:0]        in_kind,
    input logic [1:0]        in_rmode,
    input logic              in_inexact_lo,
    input logic              in_inexact_hi,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_write,
    input logic              out_error
);
    localparam int HALF = DATA_W / 2;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_write_xor_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_write ^ out_error));
    assert_compare_rejected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[2]) |=> (out_error && !out_write && out_result == $past(in_result)));
    assert_plain_modes_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rmode < 2'd2) |=> (out_result == $past(in_result)));
    assert_exact_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_inexact_lo && !(in_inexact_hi && in_fmt == 2'd2))
        |=> (out_result == $past(in_result)));
    assert_trunc_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd3) |=> (out_result == $past(in_result)));
    assert_double_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'd1 && in_kind == 3'd0 && in_rmode == 2'd2 &&
         in_inexact_lo && !in_result[DATA_W-1])
        |=> (out_result == $past(in_result) + DATA_W'(1)));
    assert_single_upper_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'd0) |=> (out_result[DATA_W-1:HALF] == $past(in_result[DATA_W-1:HALF])));
endmodule

bind dr_round_fix dr_round_fix_chk #(.DATA_W(LANE_W*LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_result     (in_result),
    .in_fmt        (in_fmt),
    .in_kind       (in_kind),
    .in_rmode      (in_rmode),
    .in_inexact_lo (in_inexact_lo),
    .in_inexact_hi (in_inexact_hi),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_write     (out_write),
    .out_error     (out_error)
);

// File: tb/dr_round_fix_test.sv
// Bench for dr_round_fix: behavioural reference, compared every clock.
module dr_round_fix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_result = '0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_kind = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_inexact_lo = 1'b0;
    logic        in_inexact_hi = 1'b0;
    logic        in_src_sign_lo = 1'b0;
    logic        in_src_sign_hi = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_write;
    logic        out_error;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          v;
        logic [63:0] res;
        bit          err;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    dr_round_fix uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
        .in_fmt(in_fmt), .in_kind(in_kind), .in_rmode(in_rmode),
        .in_inexact_lo(in_inexact_lo), .in_inexact_hi(in_inexact_hi),
        .in_src_sign_lo(in_src_sign_lo), .in_src_sign_hi(in_src_sign_hi),
        .out_valid(out_valid), .out_result(out_result),
        .out_write(out_write), .out_error(out_error)
    );

    // Reference for one 32-bit word from the requirement text.
    function automatic logic [31:0] ref_word(logic [31:0] w, bit inex, bit src,
                                             int kind, int rm);
        bit neg;
        if (!inex) return w;
        if (kind == 0)      neg = w[31];
        else if (kind == 1) neg = 0;
        else                neg = (w == 0) ? src : w[31];
        if (rm == 2 && !neg) return w + 1;
        if (rm == 3 && neg)  return (kind == 0) ? w + 1 : w - 1;
        return w;
    endfunction

    function automatic logic [63:0] ref_fix(logic [63:0] r, int fmt, int kind, int rm,
                                            bit il, bit ih, bit sl, bit sh);
        if (kind >= 3 || rm < 2) return r;
        if (fmt == 1 && kind == 0) begin
            if (il && ((rm == 2 && !r[63]) || (rm == 3 && r[63]))) return r + 64'd1;
            return r;
        end
        return {(fmt == 2) ? ref_word(r[63:32], ih, sh, kind, rm) : r[63:32],
                ref_word(r[31:0], il, sl, kind, rm)};
    endfunction

    task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic drive(logic [63:0] r, int fmt, int kind, int rm,
                         bit il, bit ih, bit sl, bit sh, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1; in_result = r; in_fmt = 2'(fmt); in_kind = 3'(kind);
        in_rmode = 2'(rm); in_inexact_lo = il; in_inexact_hi = ih;
        in_src_sign_lo = sl; in_src_sign_hi = sh;
        e.v = 1; e.res = ref_fix(r, fmt, kind, rm, il, ih, sl, sh);
        e.err = (kind >= 4); e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        in_valid = 0;
        in_result = 64'hDEAD_BEEF_0BAD_F00D;
        e.v = 0; e.res = '0; e.err = 0; e.tag = "R1";
        expq.push_back(e);
    endtask

    // Compare every cycle, a quarter period after the rising edge.
    always @(posedge clk) begin
        #5;
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (out_valid !== e.v) fail_line("R1", "valid", 64'(out_valid), 64'(e.v));
            else if (e.v) begin
                if (out_result !== e.res) fail_line(e.tag, "result", out_result, e.res);
                else if (out_error !== e.err || out_write !== !e.err)
                    fail_line("R11", "write/error", {62'd0, out_write, out_error},
                              {62'd0, !e.err, e.err});
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_write !== 0 || out_error !== 0)
            fail_line("R1", "reset state", {61'd0, out_valid, out_write, out_error}, 64'd0);

        // R2: nearest and toward-zero pass through
        drive(64'h0000_0000_3F80_0001, 0, 0, 0, 1, 1, 0, 0, "R2");
        drive(64'h0000_0000_3F80_0001, 0, 0, 1, 1, 1, 0, 0, "R2");
        // R3: exact lanes untouched; high inexact ignored outside paired
        drive(64'h1111_1111_2222_2222, 0, 0, 2, 0, 1, 0, 0, "R3");
        drive(64'h1111_1111_2222_2222, 2, 0, 2, 1, 0, 0, 0, "R3");
        // R4: truncating conversion never moves
        drive(64'h0000_0000_0000_0005, 0, 3, 2, 1, 1, 0, 0, "R4");
        // R5: toward plus infinity, positive float and integer
        drive(64'h0000_0000_3F80_0000, 0, 0, 2, 1, 0, 0, 0, "R5");
        drive(64'h0000_0000_0000_0007, 0, 2, 2, 1, 0, 0, 0, "R5");
        // R6: toward minus infinity, negative float grows, integer drops
        drive(64'h0000_0000_BF80_0000, 0, 0, 3, 1, 0, 0, 0, "R6");
        drive(64'h0000_0000_FFFF_FFF9, 0, 2, 3, 1, 0, 0, 0, "R6");
        drive(64'h0000_0000_BF80_0000, 0, 0, 2, 1, 0, 0, 0, "R6");
        // R7: double carry across the word boundary
        drive(64'h0000_0000_FFFF_FFFF, 1, 0, 2, 1, 0, 0, 0, "R7");
        drive(64'hBFF0_0000_FFFF_FFFF, 1, 0, 3, 1, 0, 0, 0, "R7");
        // R8: zero signed result takes source sign
        drive(64'h0000_0000_0000_0000, 0, 2, 3, 1, 0, 1, 0, "R8");
        drive(64'h0000_0000_0000_0000, 0, 2, 2, 1, 0, 1, 0, "R8");
        drive(64'h0000_0000_0000_0000, 0, 2, 2, 1, 0, 0, 0, "R8");
        // R9: unsigned is positive; integer upper word kept in double
        drive(64'h0000_0000_8000_0000, 0, 1, 3, 1, 0, 1, 0, "R9");
        drive(64'h5555_5555_8000_0000, 1, 1, 2, 1, 0, 0, 0, "R9");
        // R10: paired lanes independent, wrap inside lane
        drive(64'h3F80_0000_FFFF_FFFF, 2, 1, 2, 1, 1, 0, 0, "R10");
        drive(64'h0000_0000_BF80_0000, 2, 2, 3, 0, 1, 0, 1, "R10");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2, 1, 1, 0, 0, "R10");
        // R11: compare rejected
        drive(64'h0123_4567_89AB_CDEF, 0, 4, 2, 1, 1, 0, 0, "R11");
        drive(64'h0123_4567_89AB_CDEF, 2, 7, 3, 1, 1, 1, 1, "R11");
        idle();
        idle();

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) idle();
            else begin
                logic [63:0] r;
                r = {$urandom(), $urandom()};
                case ($urandom_range(0, 3))
                    0: r[31:0] = 32'h0;
                    1: r[31:0] = 32'hFFFF_FFFF;
                    default: ;
                endcase
                drive(r, $urandom_range(0, 2), $urandom_range(0, 7), $urandom_range(0, 3),
                      1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), "R10");
            end
        end
        idle();
        idle();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule